// File: doc/BRIEF.md
# Shared Functional Unit Dispatcher

This block sits between a set of instruction-issuing slots, each running its own hardware thread, and one pool of execution units that all slots share. In every cycle each slot may present one ready instruction. The instruction names the class of unit it needs, an operation qualifier, a length for variable-time branches, and a tag. The dispatcher sends instructions only to units that are free. It holds each unit busy for the latency of the operation it received. When that time has run out, the unit raises a one-cycle completion pulse that carries the slot number and the tag of its instruction.

Each class is arbitrated on its own. Within a class the slots are served in round-robin order, so when more slots ask than there are free units, every slot still gets its turn. The execution itself is modelled only as a countdown. A unit may take a new instruction in the same cycle as its completion pulse, so a one-cycle unit can accept work on every cycle. The number of slots and the number of units in each class are parameters. The defaults are four slots and two branch, two integer, one floating-point, four memory, one multiply and one divide unit.

Top module: `fu_dispatch`

## Requirements
- R1: The class field uses the codes 0 branch, 1 integer, 2 floating point, 3 memory, 4 multiply and 5 divide. A request with class 6 or 7 is never granted.
- R2: The number of instructions of a class that are in flight or granted in a cycle never exceeds the number of units of that class. A unit is never loaded while it is busy.
- R3: The dispatcher is work-conserving. In each cycle the grants for a class equal the smaller of the number of requesting slots of that class and the number of units of that class that are free in that cycle.
- R4: If an instruction is granted in cycle t, its completion pulse comes in cycle t+L. L is 1 for integer, 3 for floating point, 3 for multiply and 14 for divide.
- R5: For a branch, L depends on op. With op 0 (plain) or 3, L is 1. With op 1 (table switch), L is 5. With op 2 (lookup switch), L is the request's length field, but never less than 3.
- R6: For a memory operation, op bit 0 = 0 marks a cache hit with L = 1. Op bit 0 = 1 marks a miss with L = 4.
- R7: The completion pulse is raised on done_valid for a unit of the requested class. It carries the slot number and tag of the granted request. Units are numbered class by class in code order, so the default layout is branch 0-1, integer 2-3, floating point 4, memory 5-8, multiply 9 and divide 10.
- R8: A unit whose countdown ends in a cycle can be granted again in that same cycle. A second divide therefore starts exactly 14 cycles after the first.
- R9: The slots of a class are served round-robin. The scan begins just after the slot that was last granted in that class. With all four slots asking for the two integer units, the grants alternate between slots {0,1} and {2,3}, and no slot waits without bound.
- R10: A grant goes only to a valid request. A slot whose request is refused keeps that request unchanged until it is granted.
- R11: After reset, all units are free and no completion pulse is raised until something is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_req_valid | input | N_SLOTS | A ready instruction is offered, one bit per slot |
| slot_req_class | input | 3*N_SLOTS | Unit class code for each slot |
| slot_req_op | input | 2*N_SLOTS | Operation qualifier for each slot (branch kind, memory miss) |
| slot_req_len | input | 4*N_SLOTS | Lookup-switch branch length for each slot |
| slot_req_tag | input | TAG_W*N_SLOTS | Instruction tag for each slot |
| slot_grant | output | N_SLOTS | Request is accepted this cycle |
| done_valid | output | N_UNITS | Completion pulse for each unit |
| done_slot | output | SLOT_W*N_UNITS | Slot of the completing instruction, per unit |
| done_tag | output | TAG_W*N_UNITS | Tag of the completing instruction, per unit |

## Verification
The assertions assume that a slot keeps a refused request with a valid class stable until it is granted. The only exception is a request with an undefined class code, which may be withdrawn. The random stimulus respects this. It replaces a slot's request only in the cycle after that slot was granted, or when the slot is idle, and every directed phase runs until all of its pending requests have been granted before it removes them. The lookup lengths cover the whole 4-bit range, so they include values below the 3-cycle minimum.

// File: rtl/fu_disp_pkg.sv
// Package: shared class codes and the latency rule for the functional unit dispatcher.
// Assumes a 4-bit latency field; no class takes longer than 15 cycles.
package fu_disp_pkg;

    localparam int unsigned NUM_CLASSES = 6;
    localparam int unsigned CLS_W       = 3;
    localparam int unsigned LAT_W       = 4;

    localparam logic [CLS_W-1:0] CLS_BRANCH = 3'd0;
    localparam logic [CLS_W-1:0] CLS_INT    = 3'd1;
    localparam logic [CLS_W-1:0] CLS_FLT    = 3'd2;
    localparam logic [CLS_W-1:0] CLS_MEM    = 3'd3;
    localparam logic [CLS_W-1:0] CLS_MUL    = 3'd4;
    localparam logic [CLS_W-1:0] CLS_DIV    = 3'd5;

    localparam logic [LAT_W-1:0] CYC_INT      = 4'd1;
    localparam logic [LAT_W-1:0] CYC_FLT      = 4'd3;
    localparam logic [LAT_W-1:0] CYC_MUL      = 4'd3;
    localparam logic [LAT_W-1:0] CYC_DIV      = 4'd14;
    localparam logic [LAT_W-1:0] CYC_BR       = 4'd1;
    localparam logic [LAT_W-1:0] CYC_BR_TABLE = 4'd5;
    localparam logic [LAT_W-1:0] CYC_BR_LKMIN = 4'd3;
    localparam logic [LAT_W-1:0] CYC_MEM_HIT  = 4'd1;
    localparam logic [LAT_W-1:0] CYC_MEM_MISS = 4'd4;

    // Busy time of one operation, from its class, qualifier and lookup length.
    function automatic logic [LAT_W-1:0] lat_of(input logic [CLS_W-1:0] cls,
                                                 input logic [1:0]       op,
                                                 input logic [LAT_W-1:0] len);
        logic [LAT_W-1:0] r;
        case (cls)
            CLS_BRANCH: begin
                if (op == 2'd1)      r = CYC_BR_TABLE;
                else if (op == 2'd2) r = (len < CYC_BR_LKMIN) ? CYC_BR_LKMIN : len;
                else                 r = CYC_BR;
            end
            CLS_INT: r = CYC_INT;
            CLS_FLT: r = CYC_FLT;
            CLS_MEM: r = op[0] ? CYC_MEM_MISS : CYC_MEM_HIT;
            CLS_MUL: r = CYC_MUL;
            CLS_DIV: r = CYC_DIV;
            default: r = CYC_INT;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fu_timer.sv
// Module: one non-pipelined execution unit, modelled as a countdown.
// Loading starts a countdown of lat_in cycles (lat_in >= 1). The unit reports
// itself free in its last busy cycle, so a new load can coincide with completion.
module fu_timer #(
    parameter int unsigned LAT_W  = 4,
    parameter int unsigned SLOT_W = 2,
    parameter int unsigned TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LAT_W-1:0]  lat_in,
    input  logic [SLOT_W-1:0] slot_in,
    input  logic [TAG_W-1:0]  tag_in,
    output logic              free,
    output logic              done,
    output logic [SLOT_W-1:0] done_slot,
    output logic [TAG_W-1:0]  done_tag
);
    logic [LAT_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic [TAG_W-1:0]  tag_q;

    // Countdown and capture of the owner of the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            slot_q <= '0;
            tag_q  <= '0;
        end else if (load) begin
            cnt_q  <= lat_in;
            slot_q <= slot_in;
            tag_q  <= tag_in;
        end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign done      = (cnt_q == LAT_W'(1));
    assign free      = (cnt_q <= LAT_W'(1));
    assign done_slot = slot_q;
    assign done_tag  = tag_q;

endmodule

// File: rtl/fu_class_arb.sv
// Module: round-robin arbiter for one unit class.
// Scans the slots starting at the rotating pointer and hands each requesting
// slot the lowest-numbered free unit that has not been taken yet. The pointer
// moves just past the last slot granted. Assumes N_UNITS >= 1.
module fu_class_arb #(
    parameter int unsigned N_SLOTS = 4,
    parameter int unsigned N_UNITS = 2,
    parameter int unsigned SLOT_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SLOTS-1:0]        req,
    input  logic [N_UNITS-1:0]        unit_free,
    output logic [N_SLOTS-1:0]        grant,
    output logic [N_UNITS-1:0]        unit_load,
    output logic [N_UNITS*SLOT_W-1:0] unit_src
);
    logic [SLOT_W-1:0] ptr_q;
    logic [SLOT_W-1:0] last_s;
    logic              any_g;

    // Walk the slots in rotated order and match them to the free units.
    always_comb begin
        grant     = '0;
        unit_load = '0;
        unit_src  = '0;
        last_s    = ptr_q;
        any_g     = 1'b0;
        for (int i = 0; i < int'(N_SLOTS); i++) begin
            int   s;
            logic hit;
            s   = int'(ptr_q) + i;
            if (s >= int'(N_SLOTS)) s = s - int'(N_SLOTS);
            hit = 1'b0;
            if (req[s]) begin
                for (int u = 0; u < int'(N_UNITS); u++) begin
                    if (!hit && unit_free[u] && !unit_load[u]) begin
                        unit_load[u]                 = 1'b1;
                        unit_src[u*SLOT_W +: SLOT_W] = SLOT_W'(s);
                        hit                          = 1'b1;
                    end
                end
            end
            if (hit) begin
                grant[s] = 1'b1;
                last_s   = SLOT_W'(s);
                any_g    = 1'b1;
            end
        end
    end

    // Advance the pointer past the last slot served.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= '0;
        else if (any_g) ptr_q <= (int'(last_s) == int'(N_SLOTS) - 1) ? '0 : last_s + 1'b1;
    end

endmodule

// File: rtl/fu_dispatch.sv
// Module: shared functional unit dispatcher (top).
// Instantiates one arbiter per class and one countdown per unit. Units are
// numbered class by class in class-code order. Assumes every class count >= 1
// and that refused requests are held stable by the slots.
module fu_dispatch
    import fu_disp_pkg::*;
#(
    parameter int unsigned N_SLOTS  = 4,
    parameter int unsigned TAG_W    = 8,
    parameter int unsigned N_BRANCH = 2,
    parameter int unsigned N_INT    = 2,
    parameter int unsigned N_FLT    = 1,
    parameter int unsigned N_MEM    = 4,
    parameter int unsigned N_MUL    = 1,
    parameter int unsigned N_DIV    = 1,
    localparam int unsigned SLOT_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int unsigned N_UNITS = N_BRANCH + N_INT + N_FLT + N_MEM + N_MUL + N_DIV
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_SLOTS-1:0]          slot_req_valid,
    input  logic [N_SLOTS*3-1:0]        slot_req_class,
    input  logic [N_SLOTS*2-1:0]        slot_req_op,
    input  logic [N_SLOTS*4-1:0]        slot_req_len,
    input  logic [N_SLOTS*TAG_W-1:0]    slot_req_tag,
    output logic [N_SLOTS-1:0]          slot_grant,
    output logic [N_UNITS-1:0]          done_valid,
    output logic [N_UNITS*SLOT_W-1:0]   done_slot,
    output logic [N_UNITS*TAG_W-1:0]    done_tag
);
    // Unit count of one class.
    function automatic int unsigned units_of(input int unsigned c);
        case (c)
            0:       return N_BRANCH;
            1:       return N_INT;
            2:       return N_FLT;
            3:       return N_MEM;
            4:       return N_MUL;
            default: return N_DIV;
        endcase
    endfunction

    // Index of the first unit of one class.
    function automatic int unsigned off_of(input int unsigned c);
        int unsigned o;
        o = 0;
        for (int unsigned k = 0; k < c; k++) o += units_of(k);
        return o;
    endfunction

    logic [N_UNITS-1:0] unit_ld;
    logic [N_SLOTS-1:0] gnt_cls [NUM_CLASSES];

    for (genvar c = 0; c < int'(NUM_CLASSES); c++) begin : g_cls
        localparam int unsigned NU  = units_of(c);
        localparam int unsigned OFF = off_of(c);

        logic [N_SLOTS-1:0]   req_c;
        logic [NU-1:0]        free_c;
        logic [NU-1:0]        load_c;
        logic [NU*SLOT_W-1:0] src_c;

        // Pick out the slots that ask for this class.
        always_comb begin
            for (int s = 0; s < int'(N_SLOTS); s++)
                req_c[s] = slot_req_valid[s] && (slot_req_class[s*3 +: 3] == CLS_W'(c));
        end

        fu_class_arb #(.N_SLOTS(N_SLOTS), .N_UNITS(NU), .SLOT_W(SLOT_W)) u_arb (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req_c),
            .unit_free(free_c),
            .grant    (gnt_cls[c]),
            .unit_load(load_c),
            .unit_src (src_c)
        );

        for (genvar u = 0; u < int'(NU); u++) begin : g_unit
            logic [SLOT_W-1:0] src;
            logic [LAT_W-1:0]  lat;
            logic [TAG_W-1:0]  tag;

            assign src = src_c[u*SLOT_W +: SLOT_W];
            assign lat = lat_of(CLS_W'(c), slot_req_op[int'(src)*2 +: 2],
                                slot_req_len[int'(src)*4 +: 4]);
            assign tag = slot_req_tag[int'(src)*TAG_W +: TAG_W];
            assign unit_ld[OFF+u] = load_c[u];

            fu_timer #(.LAT_W(LAT_W), .SLOT_W(SLOT_W), .TAG_W(TAG_W)) u_tmr (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load_c[u]),
                .lat_in   (lat),
                .slot_in  (src),
                .tag_in   (tag),
                .free     (free_c[u]),
                .done     (done_valid[OFF+u]),
                .done_slot(done_slot[(OFF+u)*SLOT_W +: SLOT_W]),
                .done_tag (done_tag[(OFF+u)*TAG_W +: TAG_W])
            );
        end
    end

    // Each slot sits in at most one class, so the class grants simply merge.
    always_comb begin
        slot_grant = '0;
        for (int c = 0; c < int'(NUM_CLASSES); c++) slot_grant |= gnt_cls[c];
    end

endmodule

// File: rtl/fu_dispatch_chk.sv
// Module: assertion checker for fu_dispatch, attached by bind.
// Assumes slots hold refused requests of a defined class until granted.
module fu_dispatch_chk #(
    parameter int unsigned N_SLOTS = 4,
    parameter int unsigned N_UNITS = 11,
    parameter int unsigned INT_OFF = 2,
    parameter int unsigned N_INT   = 2,
    parameter int unsigned DIV_OFF = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_SLOTS-1:0]   slot_req_valid,
    input logic [N_SLOTS*3-1:0] slot_req_class,
    input logic [N_SLOTS-1:0]   slot_grant,
    input logic [N_UNITS-1:0]   done_valid,
    input logic [N_UNITS-1:0]   unit_ld
);
    logic seen_q;
    logic rst_seen_q;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) seen_q <= rst_n;
    // Marks that a reset has been observed at all.
    always_ff @(posedge clk) if (!rst_n) rst_seen_q <= 1'b1; else if (!rst_seen_q) rst_seen_q <= 1'b0;

    p_grant_has_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_grant & ~slot_req_valid) == '0);

    p_loads_match_grants_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(unit_ld) == $countones(slot_grant));

    p_div_not_reloaded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        unit_ld[DIV_OFF] |=> !unit_ld[DIV_OFF]);

    p_quiet_after_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen_q === 1'b1 && $past(!rst_n)) |-> done_valid == '0);

    for (genvar k = 0; k < int'(N_INT); k++) begin : g_int
        p_int_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
            unit_ld[INT_OFF+k] |=> done_valid[INT_OFF+k]);
    end

    for (genvar s = 0; s < int'(N_SLOTS); s++) begin : g_slot
        p_bad_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_req_class[s*3 +: 3] > 3'd5) |-> !slot_grant[s]);

        p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && $past(slot_req_valid[s] && !slot_grant[s] && slot_req_class[s*3 +: 3] < 3'd6))
            |-> (slot_req_valid[s] && $stable(slot_req_class[s*3 +: 3])));
    end

endmodule

bind fu_dispatch fu_dispatch_chk #(
    .N_SLOTS(N_SLOTS),
    .N_UNITS(N_UNITS),
    .INT_OFF(N_BRANCH),
    .N_INT  (N_INT),
    .DIV_OFF(N_UNITS - N_DIV)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_req_valid(slot_req_valid),
    .slot_req_class(slot_req_class),
    .slot_grant    (slot_grant),
    .done_valid    (done_valid),
    .unit_ld       (unit_ld)
);

// File: tb/fu_dispatch_bench.sv
// Bench: scoreboard model of grants and completions, directed corner cases
// followed by seeded random traffic.
module fu_dispatch_bench;
    localparam int NS = 4;
    localparam int TW = 8;
    localparam int U  = 11;
    localparam int SW = 2;
    localparam int NE = 32;

    localparam int CNT [6] = '{2, 2, 1, 4, 1, 1};
    localparam int OFF [6] = '{0, 2, 4, 5, 9, 10};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NS-1:0]    rv;
    logic [2:0]       rc [NS];
    logic [1:0]       ro [NS];
    logic [3:0]       rl [NS];
    logic [TW-1:0]    rt [NS];
    logic [NS*3-1:0]  f_cls;
    logic [NS*2-1:0]  f_op;
    logic [NS*4-1:0]  f_len;
    logic [NS*TW-1:0] f_tag;
    logic [NS-1:0]    gnt;
    logic [U-1:0]     dv;
    logic [U*SW-1:0]  dslot;
    logic [U*TW-1:0]  dtag;

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            f_cls[s*3 +: 3]   = rc[s];
            f_op[s*2 +: 2]    = ro[s];
            f_len[s*4 +: 4]   = rl[s];
            f_tag[s*TW +: TW] = rt[s];
        end
    end

    fu_dispatch u_fu_dispatch (
        .clk(clk), .rst_n(rst_n),
        .slot_req_valid(rv), .slot_req_class(f_cls), .slot_req_op(f_op),
        .slot_req_len(f_len), .slot_req_tag(f_tag),
        .slot_grant(gnt), .done_valid(dv), .done_slot(dslot), .done_tag(dtag)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic model_on = 1'b0;
    logic [NS-1:0] g_last = '0;
    logic [TW-1:0] next_tag = '0;
    int wait_c [NS];

    logic         e_act  [NE];
    int           e_due  [NE];
    int           e_cls  [NE];
    int           e_slot [NE];
    logic [TW-1:0] e_tag [NE];

    // Expected busy time from the requirements.
    function automatic int exp_lat(input int cls, input int op, input int len);
        case (cls)
            0: return (op == 1) ? 5 : (op == 2) ? ((len < 3) ? 3 : len) : 1;
            1: return 1;
            2: return 3;
            3: return (op % 2 == 1) ? 4 : 1;
            4: return 3;
            default: return 14;
        endcase
    endfunction

    function automatic int cls_of_unit(input int u);
        int r;
        r = 0;
        for (int c = 0; c < 6; c++) if (u >= OFF[c]) r = c;
        return r;
    endfunction

    function automatic string rtag(input int cls);
        return (cls == 0) ? "R5" : (cls == 3) ? "R6" : "R4";
    endfunction

    task automatic fail_line(input string req, input string what, input int act, input int exp);
        fails++;
        $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    endtask

    // Per-cycle scoreboard step, at the falling edge.
    always @(negedge clk) begin
        if (model_on) begin
            cyc++;
            for (int u = 0; u < U; u++) begin
                if (dv[u]) begin
                    int hit;
                    hit = -1;
                    for (int e = 0; e < NE; e++)
                        if (e_act[e] && e_tag[e] == dtag[u*TW +: TW] && e_slot[e] == int'(dslot[u*SW +: SW]))
                            hit = e;
                    checks++;
                    if (hit < 0) fail_line("R7", "completion without matching grant, unit", u, -1);
                    else begin
                        if (e_cls[hit] != cls_of_unit(u)) fail_line("R7", "completion unit class", cls_of_unit(u), e_cls[hit]);
                        else if (e_due[hit] != cyc) fail_line(rtag(e_cls[hit]), "completion cycle", cyc, e_due[hit]);
                        e_act[hit] = 1'b0;
                    end
                end
            end
            for (int e = 0; e < NE; e++)
                if (e_act[e] && e_due[e] <= cyc) begin
                    checks++;
                    fail_line(rtag(e_cls[e]), "missing completion, due cycle", cyc, e_due[e]);
                    e_act[e] = 1'b0;
                end
            for (int c = 0; c < 6; c++) begin
                int occ, rq, gn, ex;
                occ = 0; rq = 0; gn = 0;
                for (int e = 0; e < NE; e++) if (e_act[e] && e_cls[e] == c) occ++;
                for (int s = 0; s < NS; s++) if (rv[s] && int'(rc[s]) == c) begin
                    rq++;
                    if (gnt[s]) gn++;
                end
                ex = (rq < CNT[c] - occ) ? rq : CNT[c] - occ;
                checks++;
                if (gn > CNT[c] - occ) fail_line("R2", "grants beyond free units", gn, CNT[c] - occ);
                else if (gn != ex) fail_line("R3", "grants for class", gn, ex);
            end
            for (int s = 0; s < NS; s++) begin
                if (gnt[s] && !rv[s]) begin checks++; fail_line("R10", "grant without request", 1, 0); end
                if (gnt[s] && rc[s] > 3'd5) begin checks++; fail_line("R1", "grant to undefined class", 1, 0); end
                if (gnt[s] && rv[s] && rc[s] <= 3'd5) begin
                    int slot_e;
                    slot_e = -1;
                    for (int e = 0; e < NE; e++) if (!e_act[e] && slot_e < 0) slot_e = e;
                    if (slot_e >= 0) begin
                        e_act[slot_e]  = 1'b1;
                        e_cls[slot_e]  = int'(rc[s]);
                        e_slot[slot_e] = s;
                        e_tag[slot_e]  = rt[s];
                        e_due[slot_e]  = cyc + exp_lat(int'(rc[s]), int'(ro[s]), int'(rl[s]));
                    end
                    checks++;
                    if (wait_c[s] > 150) fail_line("R9", "wait cycles before grant", wait_c[s], 150);
                end
                if (rv[s] && !gnt[s] && rc[s] <= 3'd5) wait_c[s]++;
                else wait_c[s] = 0;
            end
            g_last = gnt;
        end
    end

    // Watchdog: a hung run still reaches the summary as a failure.
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            fails++;
            $display("FAIL watchdog expired: actual %0d expected %0d", wd, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic set_req(input int s, input int cls, input int op, input int len);
        rv[s] = 1'b1;
        rc[s] = 3'(cls);
        ro[s] = 2'(op);
        rl[s] = 4'(len);
        rt[s] = next_tag;
        next_tag++;
    endtask

    task automatic to_drive();
        @(posedge clk);
        #2;
    endtask

    // Mode 0 drops granted requests, 1 reissues the same class, 2 draws random ones.
    task automatic refresh(input int mode);
        for (int s = 0; s < NS; s++) begin
            if (!rv[s] || g_last[s]) begin
                if (mode == 0) rv[s] = 1'b0;
                else if (mode == 1) begin if (rv[s]) set_req(s, int'(rc[s]), 0, 0); end
                else if ($urandom % 10 < 7) set_req(s, $urandom % 6, $urandom % 4, $urandom % 16);
                else rv[s] = 1'b0;
            end
        end
    endtask

    task automatic drain(input int n);
        for (int k = 0; k < n; k++) begin
            to_drive();
            refresh(0);
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        rv = '0;
        for (int s = 0; s < NS; s++) begin
            rc[s] = '0; ro[s] = '0; rl[s] = '0; rt[s] = '0; wait_c[s] = 0;
        end
        for (int e = 0; e < NE; e++) begin
            e_act[e] = 1'b0; e_due[e] = 0; e_cls[e] = 0; e_slot[e] = 0; e_tag[e] = '0;
        end
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        // R11: nothing completes and nothing is granted right after reset.
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            checks++;
            if (dv != '0 || gnt != '0) fail_line("R11", "activity after reset", int'(dv), 0);
        end
        model_on = 1'b1;

        // R9 / R8: all slots ask for the two integer units, served in pairs.
        to_drive();
        for (int s = 0; s < NS; s++) set_req(s, 1, 0, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #1;
            checks++;
            if (gnt != ((k % 2 == 0) ? 4'b0011 : 4'b1100))
                fail_line("R9", "round-robin grant pattern", int'(gnt), (k % 2 == 0) ? 3 : 12);
            to_drive();
            refresh((k < 3) ? 1 : 0);
        end
        drain(4);

        // R4 / R5 / R6: single operations with each latency rule.
        begin
            int dl [9][3];
            dl = '{'{0,1,0}, '{0,2,9}, '{0,2,1}, '{0,0,0}, '{3,1,0}, '{3,0,0}, '{2,0,0}, '{4,0,0}, '{5,0,0}};
            for (int k = 0; k < 9; k++) begin
                set_req(0, dl[k][0], dl[k][1], dl[k][2]);
                @(negedge clk);
                #1;
                checks++;
                if (!gnt[0]) fail_line(rtag(dl[k][0]), "idle unit not granted", 0, 1);
                drain(17);
            end
        end

        // R1: an undefined class is never granted.
        set_req(1, 7, 0, 0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            #1;
            checks++;
            if (gnt[1]) fail_line("R1", "class 7 granted", 1, 0);
            to_drive();
        end
        rv[1] = 1'b0;

        // R8: two divides; the second starts exactly 14 cycles after the first.
        to_drive();
        set_req(2, 5, 0, 0);
        set_req(3, 5, 0, 0);
        begin
            int t0, t1;
            t0 = -1; t1 = -1;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                #1;
                if (gnt[2] && t0 < 0) t0 = cyc;
                if (gnt[3] && t1 < 0) t1 = cyc;
                to_drive();
                refresh(0);
            end
            checks++;
            if (t1 - t0 != 14) fail_line("R8", "divide reissue spacing", t1 - t0, 14);
        end

        // Random traffic across all classes and qualifiers.
        for (int k = 0; k < 4000; k++) begin
            to_drive();
            refresh(2);
        end
        for (int k = 0; k < 200; k++) begin
            to_drive();
            refresh(0);
        end
        repeat (20) @(posedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule